// File: doc/BRIEF.md
# Instruction Cache Way Parity Checker

This block audits one way of an instruction cache for parity damage. A caller first presents the way's tag as a pair of words: a 32-bit high word and a 64-bit low word. It then presents up to four data entries, one at a time. Each data entry is a 32-bit sideband word together with two 32-bit instructions. The block checks the separate protection fields of each input as it arrives. It keeps two sticky error flags, one for the tag and one for the data, and pulses a done strobe when the way is finished.

Each input is qualified by its own valid bit, and one input can be accepted on every cycle. An accepted tag starts a new way check, clears both flags, and records the result of the tag check. A control bit sent with the tag chooses one of two flows. In the first, the way closes after four data entries. In the second, data checking is skipped and the way closes at once. Data entries that arrive when no way check is open are ignored.

Top module: `icache_parity_chk`

## Requirements
- R1: Bit 29 of the tag high word is the valid bit and bit 27 is its parity copy. When the two differ, the tag error flag is set, whatever the valid bit is.
- R2: When high-word bit 29 is 1, tag-low bit 10 must equal the XOR of tag-low bits 23..0, excluding bits 10 and 11. Otherwise the tag error flag is set.
- R3: When high-word bit 29 is 1, tag-low bit 11 must equal the XOR of tag-low bits 63..24. Otherwise the tag error flag is set.
- R4: When high-word bits 29 and 27 are both 0, the tag error flag stays clear, even if the checks of R2 and R3 would fail.
- R5: In an accepted data entry, sideband bit 16 must equal the XOR of sideband bits 15..8. Otherwise the data error flag is set.
- R6: Sideband bits 7..4 hold the even parity of the bytes of instruction A, and bits 3..0 hold the same for instruction B. Within each nibble, the higher bit covers the higher byte; for example, bit 7 covers A[31:24] and bit 0 covers B[7:0]. Any mismatch sets the data error flag.
- R7: Both flags are sticky until the next accepted tag. That tag loads the tag flag with its own check result and clears the data flag. Both flags show a result in the cycle after the input that caused it is accepted.
- R8: With data checking enabled, done is high for exactly one cycle. That cycle follows the acceptance of the fourth data entry. Cycles with entry valid low are not counted, and a tag accepted while a way check is open restarts the count.
- R9: With data checking disabled, done is high in the cycle after the tag is accepted, and no data entry is accepted for that way.
- R10: A data entry presented while no way check is open, or in the same cycle as a tag, changes neither flag and does not produce done.
- R11: After reset, both flags and done are 0 and no way check is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_vld_i | input | 1 | Tag pair valid; starts a new way check |
| tag_hi_i | input | 32 | Tag high word |
| tag_lo_i | input | 64 | Tag low word |
| chk_data_i | input | 1 | Sent with the tag; 1 enables the four data entries |
| ent_vld_i | input | 1 | Data entry valid |
| ent_side_i | input | 32 | Data entry sideband word |
| ent_insn_a_i | input | 32 | Data entry instruction A |
| ent_insn_b_i | input | 32 | Data entry instruction B |
| tag_err_o | output | 1 | Sticky tag parity error |
| data_err_o | output | 1 | Sticky data parity error |
| done_o | output | 1 | One-cycle way-complete strobe |

## Verification
Every result here is due exactly one cycle after the edge that accepts its input. The tag flag reflects the tag accepted on the previous edge. The data flag includes the entry accepted on the previous edge. Done rises one cycle after the fourth entry, or one cycle after a tag sent with data checking disabled. The bench changes inputs on the falling edge, so each call spans exactly one accepting rising edge. It then reads the outputs at the next falling edge, half a period after that edge. Every flag and done check therefore lands in the first cycle the new value is due. Extra falling-edge samples confirm that done is low again one cycle later.

// File: rtl/icp_pkg.sv
package icp_pkg;
  // word widths
  localparam int TAG_HI_W    = 32;
  localparam int TAG_LO_W    = 64;
  localparam int SIDE_W      = 32;
  localparam int INSN_W      = 32;
  localparam int BYTES_PER_I = INSN_W / 8;
  // tag high word fields
  localparam int VLD_BIT     = 29;
  localparam int VLD_PAR_BIT = 27;
  // tag low word fields
  localparam int LO_PAR0_BIT = 10;
  localparam int LO_PAR1_BIT = 11;
  localparam int LO_SPLIT    = 24;
  // sideband fields
  localparam int PRE_LSB     = 8;
  localparam int PRE_W       = 8;
  localparam int PRE_PAR_BIT = 16;
endpackage

// File: rtl/icp_tag_check.sv
module icp_tag_check
  import icp_pkg::*;
(
  input  logic [TAG_HI_W-1:0] hi_i,
  input  logic [TAG_LO_W-1:0] lo_i,
  output logic                bad_o
);
  localparam logic [LO_SPLIT-1:0] LOW_MASK =
    ~((LO_SPLIT'(1) << LO_PAR0_BIT) | (LO_SPLIT'(1) << LO_PAR1_BIT));

  logic vld;
  logic vld_bad;
  logic low_par;
  logic high_par;
  logic rng_bad;
  logic hi_unused;

  assign hi_unused = ^hi_i;

  always_comb begin
    vld      = hi_i[VLD_BIT];
    vld_bad  = hi_i[VLD_BIT] ^ hi_i[VLD_PAR_BIT];
    low_par  = ^(lo_i[LO_SPLIT-1:0] & LOW_MASK);
    high_par = ^lo_i[TAG_LO_W-1:LO_SPLIT];
    rng_bad  = vld & ((low_par ^ lo_i[LO_PAR0_BIT]) | (high_par ^ lo_i[LO_PAR1_BIT]));
    bad_o    = vld_bad | rng_bad;
  end
endmodule

// File: rtl/icp_entry_check.sv
module icp_entry_check
  import icp_pkg::*;
(
  input  logic [SIDE_W-1:0] side_i,
  input  logic [INSN_W-1:0] insn_a_i,
  input  logic [INSN_W-1:0] insn_b_i,
  output logic              bad_o
);
  logic [BYTES_PER_I-1:0] par_a;
  logic [BYTES_PER_I-1:0] par_b;
  logic                   pre_bad;
  logic                   a_bad;
  logic                   b_bad;
  logic                   side_unused;

  assign side_unused = ^side_i;

  for (genvar g = 0; g < BYTES_PER_I; g++) begin : g_byte
    assign par_a[g] = ^insn_a_i[8*g +: 8];
    assign par_b[g] = ^insn_b_i[8*g +: 8];
  end

  always_comb begin
    pre_bad = side_i[PRE_PAR_BIT] ^ (^side_i[PRE_LSB +: PRE_W]);
    a_bad   = |(par_a ^ side_i[2*BYTES_PER_I-1:BYTES_PER_I]);
    b_bad   = |(par_b ^ side_i[BYTES_PER_I-1:0]);
    bad_o   = pre_bad | a_bad | b_bad;
  end
endmodule

// File: rtl/icp_seq.sv
module icp_seq #(
  parameter int NUM_ENTRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_vld_i,
  input  logic chk_data_i,
  input  logic tag_bad_i,
  input  logic ent_vld_i,
  input  logic ent_bad_i,
  output logic tag_err_o,
  output logic data_err_o,
  output logic done_o
);
  localparam int              CNT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ENTRIES - 1);

  logic             open_q,     open_d;
  logic [CNT_W-1:0] cnt_q,      cnt_d;
  logic             tag_err_q,  tag_err_d;
  logic             data_err_q, data_err_d;
  logic             done_q,     done_d;
  logic             ent_take;
  logic             state_en;

  assign ent_take = ent_vld_i & open_q & ~tag_vld_i;
  assign state_en = tag_vld_i | ent_take;

  // next state
  always_comb begin
    open_d     = open_q;
    cnt_d      = cnt_q;
    tag_err_d  = tag_err_q;
    data_err_d = data_err_q;
    done_d     = 1'b0;
    if (tag_vld_i) begin
      open_d     = chk_data_i;
      cnt_d      = '0;
      tag_err_d  = tag_bad_i;
      data_err_d = 1'b0;
      done_d     = ~chk_data_i;
    end else if (ent_take) begin
      data_err_d = data_err_q | ent_bad_i;
      if (cnt_q == LAST) begin
        open_d = 1'b0;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  // state registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      cnt_q      <= '0;
      tag_err_q  <= 1'b0;
      data_err_q <= 1'b0;
    end else if (state_en) begin
      open_q     <= open_d;
      cnt_q      <= cnt_d;
      tag_err_q  <= tag_err_d;
      data_err_q <= data_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign tag_err_o  = tag_err_q;
  assign data_err_o = data_err_q;
  assign done_o     = done_q;

  // R8: done only when no way check is left open
  p_done_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !open_q);
  // R8: counter never passes the last entry
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (cnt_q <= LAST));
  // R7: a tag clears the data flag
  p_tag_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tag_vld_i |=> !data_err_q);
  // R7: the data flag only falls on a tag
  p_data_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_vld_i && data_err_q) |=> data_err_q);
  // R7: the tag flag only changes on a tag
  p_tag_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_vld_i |=> $stable(tag_err_q));
  // R9: skipping data closes the way at once
  p_nodata_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_vld_i && !chk_data_i) |=> done_q);
  // R10: entries outside an open check do nothing
  p_stray_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld_i && !open_q && !tag_vld_i) |=> ($stable(data_err_q) && !done_q));
endmodule

// File: rtl/icache_parity_chk.sv
module icache_parity_chk
  import icp_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tag_vld_i,
  input  logic [TAG_HI_W-1:0] tag_hi_i,
  input  logic [TAG_LO_W-1:0] tag_lo_i,
  input  logic                chk_data_i,
  input  logic                ent_vld_i,
  input  logic [SIDE_W-1:0]   ent_side_i,
  input  logic [INSN_W-1:0]   ent_insn_a_i,
  input  logic [INSN_W-1:0]   ent_insn_b_i,
  output logic                tag_err_o,
  output logic                data_err_o,
  output logic                done_o
);
  logic tag_bad;
  logic ent_bad;

  icp_tag_check u_tag (
    .hi_i  (tag_hi_i),
    .lo_i  (tag_lo_i),
    .bad_o (tag_bad)
  );

  icp_entry_check u_ent (
    .side_i   (ent_side_i),
    .insn_a_i (ent_insn_a_i),
    .insn_b_i (ent_insn_b_i),
    .bad_o    (ent_bad)
  );

  icp_seq #(.NUM_ENTRIES(NUM_ENTRIES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag_vld_i  (tag_vld_i),
    .chk_data_i (chk_data_i),
    .tag_bad_i  (tag_bad),
    .ent_vld_i  (ent_vld_i),
    .ent_bad_i  (ent_bad),
    .tag_err_o  (tag_err_o),
    .data_err_o (data_err_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/icache_parity_chk_tb.sv
module icache_parity_chk_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tag_vld, chk_data, ent_vld;
  logic [31:0] tag_hi;
  logic [63:0] tag_lo;
  logic [31:0] side, ia, ib;
  logic        tag_err, data_err, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  localparam logic [31:0] HI_OK  = 32'h2800_0000;
  localparam logic [31:0] HI_INV = 32'h0000_0000;

  icache_parity_chk u_dut (
    .clk(clk), .rst_n(rst_n),
    .tag_vld_i(tag_vld), .tag_hi_i(tag_hi), .tag_lo_i(tag_lo), .chk_data_i(chk_data),
    .ent_vld_i(ent_vld), .ent_side_i(side), .ent_insn_a_i(ia), .ent_insn_b_i(ib),
    .tag_err_o(tag_err), .data_err_o(data_err), .done_o(done)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // set tag-low parity bits from the R2/R3 rules
  function automatic logic [63:0] fix_lo(input logic [63:0] raw);
    logic [63:0] r;
    logic p0, p1;
    r = raw; r[10] = 1'b0; r[11] = 1'b0; p0 = 1'b0; p1 = 1'b0;
    for (int i = 0; i < 24; i++) p0 = p0 ^ r[i];
    for (int i = 24; i < 64; i++) p1 = p1 ^ r[i];
    r[10] = p0; r[11] = p1;
    return r;
  endfunction

  // build a correct sideband from the R5/R6 rules
  function automatic logic [31:0] mk_side(input logic [7:0] pre, input logic [31:0] a,
                                          input logic [31:0] b);
    logic [31:0] s;
    s = 32'h0; s[15:8] = pre;
    for (int i = 0; i < 8; i++) s[16] = s[16] ^ pre[i];
    for (int j = 0; j < 4; j++)
      for (int i = 0; i < 8; i++) begin
        s[4+j] = s[4+j] ^ a[8*j+i];
        s[j]   = s[j]   ^ b[8*j+i];
      end
    return s;
  endfunction

  task automatic send_tag(input logic [31:0] hi, input logic [63:0] lo, input logic cd);
    tag_vld = 1'b1; tag_hi = hi; tag_lo = lo; chk_data = cd; ent_vld = 1'b0;
    @(negedge clk);
    tag_vld = 1'b0;
  endtask

  task automatic send_ent(input logic [31:0] s, input logic [31:0] a, input logic [31:0] b);
    ent_vld = 1'b1; side = s; ia = a; ib = b;
    @(negedge clk);
    ent_vld = 1'b0;
  endtask

  task automatic send_good_ent(input logic [31:0] seed);
    send_ent(mk_side(seed[7:0], seed, ~seed), seed, ~seed);
  endtask

  task automatic t_reset;
    chk("R11 tag_err after reset", tag_err, 1'b0);
    chk("R11 data_err after reset", data_err, 1'b0);
    chk("R11 done after reset", done, 1'b0);
    send_good_ent(32'hDEAD_BEEF);
    chk("R11 no open check after reset", done, 1'b0);
  endtask

  task automatic t_clean;
    send_tag(HI_OK, fix_lo(64'h1234_5678_9ABC_DEF0), 1'b1);
    chk("R1 clean tag", tag_err, 1'b0);
    for (int k = 0; k < 4; k++) begin
      send_good_ent(32'h0F1E_2D3C + 32'(k * 7919));
      if (k < 3) chk("R8 done early", done, 1'b0);
      if (k == 1) begin
        @(negedge clk);
        chk("R8 gap not counted", done, 1'b0);
      end
    end
    chk("R8 done after fourth", done, 1'b1);
    chk("R5 clean data", data_err, 1'b0);
    @(negedge clk);
    chk("R8 done one cycle", done, 1'b0);
  endtask

  task automatic t_valid_par;
    send_tag(32'h2000_0000, fix_lo(64'h55), 1'b0);
    chk("R1 valid set copy clear", tag_err, 1'b1);
    send_tag(32'h0800_0000, fix_lo(64'h55), 1'b0);
    chk("R1 valid clear copy set", tag_err, 1'b1);
  endtask

  task automatic t_ranges;
    logic [63:0] g;
    g = fix_lo(64'hA5A5_0F0F_3C3C_9696);
    send_tag(HI_OK, g ^ 64'h20, 1'b0);
    chk("R2 flip low-range bit", tag_err, 1'b1);
    send_tag(HI_OK, g ^ 64'h400, 1'b0);
    chk("R2 flip parity bit 10", tag_err, 1'b1);
    send_tag(HI_OK, g ^ 64'hA0, 1'b0);
    chk("R2 two flips even", tag_err, 1'b0);
    send_tag(HI_OK, g ^ (64'h1 << 40), 1'b0);
    chk("R3 flip high-range bit", tag_err, 1'b1);
    send_tag(HI_OK, g ^ (64'h1 << 63), 1'b0);
    chk("R3 flip bit 63", tag_err, 1'b1);
    send_tag(HI_OK, g ^ 64'h800, 1'b0);
    chk("R3 flip parity bit 11", tag_err, 1'b1);
    send_tag(HI_INV, g ^ 64'h20 ^ (64'h1 << 40), 1'b0);
    chk("R4 invalid entry ignores ranges", tag_err, 1'b0);
  endtask

  task automatic t_predecode;
    logic [31:0] s;
    send_tag(HI_OK, fix_lo(64'h77), 1'b1);
    send_good_ent(32'h1111_2222);
    chk("R5 first clean", data_err, 1'b0);
    s = mk_side(8'h3A, 32'h0, 32'h0) ^ 32'h0001_0000;
    send_ent(s, 32'h0, 32'h0);
    chk("R5 predecode parity bad", data_err, 1'b1);
    send_good_ent(32'h3333_4444);
    chk("R7 data flag sticky", data_err, 1'b1);
    send_good_ent(32'h5555_6666);
    chk("R7 sticky at done", data_err, 1'b1);
    chk("R8 done with error", done, 1'b1);
    send_tag(HI_OK, fix_lo(64'h99), 1'b1);
    chk("R7 new tag clears data flag", data_err, 1'b0);
    chk("R7 new tag clean tag flag", tag_err, 1'b0);
  endtask

  task automatic t_insn;
    send_tag(HI_OK, fix_lo(64'hC0FFEE), 1'b1);
    send_ent(32'h0000_0080, 32'h0100_0000, 32'h0);
    chk("R6 bit7 covers A top byte", data_err, 1'b0);
    send_ent(32'h0000_0001, 32'h0, 32'h0000_0001);
    chk("R6 bit0 covers B low byte", data_err, 1'b0);
    send_ent(32'h0000_0010, 32'h0000_0000, 32'h0);
    chk("R6 A parity mismatch", data_err, 1'b1);
    send_good_ent(32'h0);
    chk("R8 done after insn way", done, 1'b1);
    send_tag(HI_OK, fix_lo(64'hC0FFEE), 1'b1);
    send_ent(32'h0000_0008, 32'h0, 32'h0);
    chk("R6 B parity mismatch", data_err, 1'b1);
  endtask

  task automatic t_nodata;
    send_tag(HI_OK, fix_lo(64'h1234), 1'b0);
    chk("R9 done right after tag", done, 1'b1);
    send_ent(32'h0001_0000, 32'h0, 32'h0);
    chk("R10 entry after close ignored", data_err, 1'b0);
    chk("R9 no second done", done, 1'b0);
    tag_vld = 1'b1; tag_hi = HI_OK; tag_lo = fix_lo(64'h1); chk_data = 1'b1;
    ent_vld = 1'b1; side = 32'h0001_0000; ia = 32'h0; ib = 32'h0;
    @(negedge clk);
    tag_vld = 1'b0; ent_vld = 1'b0;
    chk("R10 entry with tag ignored", data_err, 1'b0);
    for (int k = 0; k < 3; k++) send_good_ent(32'h42 + 32'(k));
    chk("R10 same-cycle entry not counted", done, 1'b0);
    send_good_ent(32'h99);
    chk("R8 done after four", done, 1'b1);
  endtask

  task automatic t_restart;
    send_tag(32'h2000_0000, fix_lo(64'h5), 1'b1);
    chk("R1 restart first tag bad", tag_err, 1'b1);
    send_good_ent(32'hAB);
    send_good_ent(32'hCD);
    send_tag(HI_OK, fix_lo(64'h6), 1'b1);
    chk("R7 restart clears tag flag", tag_err, 1'b0);
    for (int k = 0; k < 3; k++) send_good_ent(32'h10 + 32'(k));
    chk("R8 restart resets count", done, 1'b0);
    send_good_ent(32'h20);
    chk("R8 done after restart", done, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; tag_vld = 1'b0; chk_data = 1'b0; ent_vld = 1'b0;
    tag_hi = '0; tag_lo = '0; side = '0; ia = '0; ib = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_clean;
    t_valid_par;
    t_ranges;
    t_predecode;
    t_insn;
    t_nodata;
    t_restart;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule